// File: doc/BRIEF.md
# Signed Pending-Acknowledgement Tracker

This block keeps a small, fully associative table of outstanding write misses, one entry per line address. Each entry carries a signed two's-complement balance of coherence messages still owed, plus a snapshot of the line's transient state, its data word and a dirty bit. That snapshot lets a writeback be served while the miss is still open. A new entry starts with a balance of zero.

Every data reply, plain acknowledgement or returned self-request carries a signed field. The entry's balance becomes the balance minus that field. A data reply that announces N outstanding acknowledgements drives the balance to -N. Each plain acknowledgement carries -1 and so moves the balance up by one, and the messages may arrive in any order.

Whenever an update leaves the balance at exactly zero, the line address is pushed once into an in-order completion queue. A downstream consumer pops that queue. Message decoding and the coherence controller itself sit outside this block.

Each table slot is a two-state machine. SLOT_FREE moves to SLOT_BUSY on an accepted allocate (transition "claim"). SLOT_BUSY moves back to SLOT_FREE on a matching deallocate (transition "release"). In every other case a slot holds its state.

Top module: `pat_tracker`

## Requirements
- R1: After reset, no address hits on lookup, `full` is 0, `trig_valid` is 0, and `upd_err` and `trig_ovf` are 0.
- R2: An allocate for an address that is absent, while a slot is free, gives `alloc_ok`=1 in the same cycle. From the next cycle, a lookup of that address hits with count 0 and returns the stored state, data and dirty bit.
- R3: An update to a held address sets its count, from the next cycle, to old count minus `upd_delta`, in CNT_W-bit two's complement with wraparound. Other entries are unchanged.
- R4: A negative delta raises the count. A delta of -1 (8'hFF) adds one.
- R5: An update whose result is exactly zero pushes its address into the completion queue once. `trig_valid` is 1 in the next cycle, with `trig_addr` equal to that address. A non-zero result pushes nothing.
- R6: An update to an address that is not held sets `upd_err` to 1 for exactly one cycle, in the next cycle. It changes no count and pushes nothing.
- R7: When all ENTRIES slots are held, `full`=1 and an allocate is refused (`alloc_ok`=0). The refused address does not become held.
- R8: An allocate for an address already held is refused (`alloc_ok`=0).
- R9: A deallocate of a held address frees its slot. From the next cycle, lookup misses and `full` drops.
- R10: The completion queue holds QDEPTH addresses. It returns them in push order, one per cycle in which `trig_pop`=1 while `trig_valid`=1.
- R11: A push while the queue is full and not being popped is dropped. `trig_ovf` is 1 for one cycle, in the next cycle, and the queued contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_addr | input | ADDR_W | Line address to allocate |
| alloc_state | input | ST_W | Transient state snapshot |
| alloc_data | input | DATA_W | Data snapshot |
| alloc_dirty | input | 1 | Dirty snapshot |
| alloc_ok | output | 1 | Allocate accepted (combinational) |
| full | output | 1 | All slots held |
| dealloc_valid | input | 1 | Deallocate request |
| dealloc_addr | input | ADDR_W | Line address to free |
| upd_valid | input | 1 | Count update request |
| upd_addr | input | ADDR_W | Line address to update |
| upd_delta | input | CNT_W | Signed field subtracted from the count |
| upd_err | output | 1 | Update missed the table (one-cycle pulse) |
| lkp_addr | input | ADDR_W | Lookup address |
| lkp_hit | output | 1 | Lookup address is held |
| lkp_count | output | CNT_W | Count of the held entry |
| lkp_state | output | ST_W | Stored state |
| lkp_data | output | DATA_W | Stored data |
| lkp_dirty | output | 1 | Stored dirty bit |
| trig_valid | output | 1 | Completion queue not empty |
| trig_addr | output | ADDR_W | Address at the head of the queue |
| trig_pop | input | 1 | Consume the head entry |
| trig_ovf | output | 1 | Push dropped on a full queue (one-cycle pulse) |

## Verification
The assertions assume that a deallocate and an update never name the same address in the same cycle. They also assume that `trig_pop` is raised only while `trig_valid` is 1. The stimulus drives at most one operation per cycle, except for the deliberate refusal cases, and pops only after it has seen a queued entry. The overflow case is reached by pushing zero deltas on held addresses while nothing is popped, so each push is a legal update.

// File: rtl/pat_pkg.sv
package pat_pkg;
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_st_t;
endpackage

// File: rtl/pat_slot.sv
module pat_slot
    import pat_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32,
    parameter int ST_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic                     dealloc_en,
    input  logic                     upd_en,
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic [ST_W-1:0]          in_state,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     in_dirty,
    input  logic signed [CNT_W-1:0]  delta,
    output logic                     busy,
    output logic [ADDR_W-1:0]        addr_q,
    output logic signed [CNT_W-1:0]  cnt_q,
    output logic [ST_W-1:0]          state_q,
    output logic [DATA_W-1:0]        data_q,
    output logic                     dirty_q
);
    slot_st_t st_q, st_d;

    // next-state: claim / release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_FREE: if (alloc_en)   st_d = SLOT_BUSY;
            SLOT_BUSY: if (dealloc_en) st_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_FREE;
        else        st_q <= st_d;
    end

    // payload and balance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            state_q <= '0;
            data_q  <= '0;
            dirty_q <= 1'b0;
        end else if (alloc_en) begin
            addr_q  <= in_addr;
            cnt_q   <= '0;
            state_q <= in_state;
            data_q  <= in_data;
            dirty_q <= in_dirty;
        end else if (upd_en) begin
            cnt_q   <= cnt_q - delta;
        end
    end

    assign busy = (st_q == SLOT_BUSY);
endmodule

// File: rtl/pat_trig_fifo.sv
module pat_trig_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         is_full,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop, do_push;

    assign out_valid = (cnt_q != '0);
    assign is_full   = (cnt_q == CNT_W'(DEPTH));
    assign do_pop    = pop && out_valid;
    assign do_push   = push && (!is_full || do_pop);
    assign out_data  = mem[rd_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && !do_push;
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end
endmodule

// File: rtl/pat_tracker.sv
module pat_tracker
    import pat_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 32,
    parameter int ST_W    = 4,
    parameter int ENTRIES = 4,
    parameter int QDEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic [ADDR_W-1:0]        alloc_addr,
    input  logic [ST_W-1:0]          alloc_state,
    input  logic [DATA_W-1:0]        alloc_data,
    input  logic                     alloc_dirty,
    output logic                     alloc_ok,
    output logic                     full,
    input  logic                     dealloc_valid,
    input  logic [ADDR_W-1:0]        dealloc_addr,
    input  logic                     upd_valid,
    input  logic [ADDR_W-1:0]        upd_addr,
    input  logic signed [CNT_W-1:0]  upd_delta,
    output logic                     upd_err,
    input  logic [ADDR_W-1:0]        lkp_addr,
    output logic                     lkp_hit,
    output logic [CNT_W-1:0]         lkp_count,
    output logic [ST_W-1:0]          lkp_state,
    output logic [DATA_W-1:0]        lkp_data,
    output logic                     lkp_dirty,
    output logic                     trig_valid,
    output logic [ADDR_W-1:0]        trig_addr,
    input  logic                     trig_pop,
    output logic                     trig_ovf
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]       busy;
    logic [ADDR_W-1:0]        slot_addr  [ENTRIES];
    logic signed [CNT_W-1:0]  slot_cnt   [ENTRIES];
    logic [ST_W-1:0]          slot_state [ENTRIES];
    logic [DATA_W-1:0]        slot_data  [ENTRIES];
    logic [ENTRIES-1:0]       slot_dirty;

    logic [ENTRIES-1:0] alloc_hit_vec, dealloc_hit_vec, upd_hit_vec, lkp_hit_vec;
    logic [IDX_W-1:0]   free_idx;
    logic               alloc_dup, upd_hit, trig_push, q_full;
    logic signed [CNT_W-1:0] sel_cnt, new_cnt;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            assign alloc_hit_vec[g]   = busy[g] && (slot_addr[g] == alloc_addr);
            assign dealloc_hit_vec[g] = busy[g] && (slot_addr[g] == dealloc_addr);
            assign upd_hit_vec[g]     = busy[g] && (slot_addr[g] == upd_addr);
            assign lkp_hit_vec[g]     = busy[g] && (slot_addr[g] == lkp_addr);

            pat_slot #(
                .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ST_W(ST_W)
            ) slot_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc_en  (alloc_ok && (free_idx == IDX_W'(g))),
                .dealloc_en(dealloc_valid && dealloc_hit_vec[g]),
                .upd_en    (upd_valid && upd_hit_vec[g]),
                .in_addr   (alloc_addr),
                .in_state  (alloc_state),
                .in_data   (alloc_data),
                .in_dirty  (alloc_dirty),
                .delta     (upd_delta),
                .busy      (busy[g]),
                .addr_q    (slot_addr[g]),
                .cnt_q     (slot_cnt[g]),
                .state_q   (slot_state[g]),
                .data_q    (slot_data[g]),
                .dirty_q   (slot_dirty[g])
            );
        end
    endgenerate

    // lowest-numbered free slot
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy[i]) free_idx = IDX_W'(i);
        end
    end

    assign full      = &busy;
    assign alloc_dup = |alloc_hit_vec;
    assign alloc_ok  = alloc_valid && !full && !alloc_dup;
    assign upd_hit   = |upd_hit_vec;

    // one-hot selection of update and lookup entries
    always_comb begin
        sel_cnt   = '0;
        lkp_count = '0;
        lkp_state = '0;
        lkp_data  = '0;
        lkp_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (upd_hit_vec[i]) sel_cnt = sel_cnt | slot_cnt[i];
            if (lkp_hit_vec[i]) begin
                lkp_count = lkp_count | slot_cnt[i];
                lkp_state = lkp_state | slot_state[i];
                lkp_data  = lkp_data  | slot_data[i];
                lkp_dirty = lkp_dirty | slot_dirty[i];
            end
        end
    end
    assign lkp_hit = |lkp_hit_vec;

    assign new_cnt   = sel_cnt - upd_delta;
    assign trig_push = upd_valid && upd_hit && (new_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) upd_err <= 1'b0;
        else        upd_err <= upd_valid && !upd_hit;
    end

    pat_trig_fifo #(.W(ADDR_W), .DEPTH(QDEPTH)) trig_q_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (trig_push),
        .push_data(upd_addr),
        .pop      (trig_pop),
        .out_valid(trig_valid),
        .out_data (trig_addr),
        .is_full  (q_full),
        .ovf      (trig_ovf)
    );
endmodule

// File: rtl/pat_tracker_chk.sv
module pat_tracker_chk #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid,
    input logic               dealloc_valid,
    input logic               alloc_ok,
    input logic               full,
    input logic               upd_valid,
    input logic               upd_hit,
    input logic               upd_err,
    input logic               trig_push,
    input logic               q_full,
    input logic               trig_pop,
    input logic               trig_ovf,
    input logic               trig_valid,
    input logic [ENTRIES-1:0] upd_hit_vec
);
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid && !dealloc_valid) |=> full);

    // R7
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ok);

    // R6
    miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_hit) |=> upd_err);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |-> $past(upd_valid && !upd_hit));

    // R5
    push_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_push |=> trig_valid);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_push && q_full && !trig_pop) |=> trig_ovf);

    // R8
    unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_hit_vec));
endmodule

bind pat_tracker pat_tracker_chk #(.ENTRIES(ENTRIES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .dealloc_valid(dealloc_valid),
    .alloc_ok     (alloc_ok),
    .full         (full),
    .upd_valid    (upd_valid),
    .upd_hit      (upd_hit),
    .upd_err      (upd_err),
    .trig_push    (trig_push),
    .q_full       (q_full),
    .trig_pop     (trig_pop),
    .trig_ovf     (trig_ovf),
    .trig_valid   (trig_valid),
    .upd_hit_vec  (upd_hit_vec)
);

// File: tb/pat_tracker_tb.sv
module pat_tracker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        alloc_valid = 0, alloc_dirty = 0, dealloc_valid = 0, upd_valid = 0, trig_pop = 0;
    logic [15:0] alloc_addr = 0, dealloc_addr = 0, upd_addr = 0, lkp_addr = 0;
    logic [3:0]  alloc_state = 0;
    logic [31:0] alloc_data = 0;
    logic signed [7:0] upd_delta = 0;
    logic        alloc_ok, full, upd_err, lkp_hit, lkp_dirty, trig_valid, trig_ovf;
    logic [7:0]  lkp_count;
    logic [3:0]  lkp_state;
    logic [31:0] lkp_data;
    logic [15:0] trig_addr;

    pat_tracker dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_state(alloc_state),
        .alloc_data(alloc_data), .alloc_dirty(alloc_dirty), .alloc_ok(alloc_ok), .full(full),
        .dealloc_valid(dealloc_valid), .dealloc_addr(dealloc_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_delta(upd_delta), .upd_err(upd_err),
        .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_count(lkp_count), .lkp_state(lkp_state),
        .lkp_data(lkp_data), .lkp_dirty(lkp_dirty),
        .trig_valid(trig_valid), .trig_addr(trig_addr), .trig_pop(trig_pop), .trig_ovf(trig_ovf)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    localparam logic [1:0] OP_ALLOC = 2'd0, OP_UPD = 2'd1, OP_FREE = 2'd2, OP_POP = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  delta;
        logic        exp_hit;
        logic [7:0]  exp_cnt;
        logic        exp_tv;
        logic [15:0] exp_ta;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{OP_ALLOC, 16'h0100, 8'h00, 1'b1, 8'h00, 1'b0, 16'h0000}, // R2
        '{OP_UPD,   16'h0100, 8'h02, 1'b1, 8'hFE, 1'b0, 16'h0000}, // R3
        '{OP_UPD,   16'h0100, 8'hFF, 1'b1, 8'hFF, 1'b0, 16'h0000}, // R4
        '{OP_UPD,   16'h0100, 8'hFF, 1'b1, 8'h00, 1'b1, 16'h0100}, // R5
        '{OP_POP,   16'h0100, 8'h00, 1'b1, 8'h00, 1'b0, 16'h0000}, // R10
        '{OP_ALLOC, 16'h0200, 8'h00, 1'b1, 8'h00, 1'b0, 16'h0000}, // R2
        '{OP_UPD,   16'h0200, 8'hFF, 1'b1, 8'h01, 1'b0, 16'h0000}, // R4
        '{OP_UPD,   16'h0200, 8'h01, 1'b1, 8'h00, 1'b1, 16'h0200}, // R5
        '{OP_UPD,   16'h0200, 8'h80, 1'b1, 8'h80, 1'b1, 16'h0200}, // R3 wrap
        '{OP_POP,   16'h0200, 8'h00, 1'b1, 8'h80, 1'b0, 16'h0000}, // R10
        '{OP_FREE,  16'h0100, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000}  // R9
    };

    // drive one operation for one cycle, then leave inputs idle
    task automatic do_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        alloc_valid   = (op == OP_ALLOC);
        alloc_addr    = a;
        alloc_state   = 4'h3;
        alloc_data    = {16'hC0DE, a};
        alloc_dirty   = 1'b1;
        dealloc_valid = (op == OP_FREE);
        dealloc_addr  = a;
        upd_valid     = (op == OP_UPD);
        upd_addr      = a;
        upd_delta     = d;
        trig_pop      = (op == OP_POP);
        @(negedge clk);
        alloc_valid = 0; dealloc_valid = 0; upd_valid = 0; trig_pop = 0;
        lkp_addr = a;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        lkp_addr = 16'h0100;
        #1;
        check("R1 lkp_hit", {31'd0, lkp_hit}, 0);
        check("R1 full", {31'd0, full}, 0);
        check("R1 trig_valid", {31'd0, trig_valid}, 0);
        check("R1 errs", {30'd0, upd_err, trig_ovf}, 0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].addr, VECS[i].delta);
            check("R2/R3/R4/R9 hit", {31'd0, lkp_hit}, {31'd0, VECS[i].exp_hit});
            check("R3/R4 count", {24'd0, lkp_count}, {24'd0, VECS[i].exp_cnt});
            check("R5/R10 trig_valid", {31'd0, trig_valid}, {31'd0, VECS[i].exp_tv});
            if (VECS[i].exp_tv)
                check("R5 trig_addr", {16'd0, trig_addr}, {16'd0, VECS[i].exp_ta});
        end

        // R2 stored snapshot of the held 0x200 line
        lkp_addr = 16'h0200; #1;
        check("R2 state", {28'd0, lkp_state}, 32'h3);
        check("R2 data", lkp_data, 32'hC0DE0200);
        check("R2 dirty", {31'd0, lkp_dirty}, 1);

        // R7: fill the table
        do_op(OP_ALLOC, 16'h0300, 0);
        do_op(OP_ALLOC, 16'h0400, 0);
        do_op(OP_ALLOC, 16'h0500, 0);
        check("R7 full", {31'd0, full}, 1);
        @(negedge clk);
        alloc_valid = 1; alloc_addr = 16'h0600; #1;
        check("R7 alloc_ok", {31'd0, alloc_ok}, 0);
        @(negedge clk);
        alloc_valid = 0; lkp_addr = 16'h0600; #1;
        check("R7 refused not held", {31'd0, lkp_hit}, 0);

        // R9 then R8
        do_op(OP_FREE, 16'h0500, 0);
        check("R9 full drops", {31'd0, full}, 0);
        check("R9 lookup miss", {31'd0, lkp_hit}, 0);
        @(negedge clk);
        alloc_valid = 1; alloc_addr = 16'h0300; #1;
        check("R8 dup refused", {31'd0, alloc_ok}, 0);
        alloc_addr = 16'h0700; #1;
        check("R2 fresh accepted", {31'd0, alloc_ok}, 1);
        alloc_valid = 0;

        // R6: update miss
        do_op(OP_UPD, 16'h0999, 8'h00);
        check("R6 upd_err pulse", {31'd0, upd_err}, 1);
        check("R6 no push", {31'd0, trig_valid}, 0);
        lkp_addr = 16'h0200; #1;
        check("R6 count untouched", {24'd0, lkp_count}, 32'h80);
        @(negedge clk); #1;
        check("R6 upd_err one cycle", {31'd0, upd_err}, 0);

        // R11 / R10: fill queue with zero-delta updates
        do_op(OP_UPD, 16'h0200, 8'h80); // 0x80 - 0x80 = 0, push
        do_op(OP_UPD, 16'h0300, 8'h00);
        do_op(OP_UPD, 16'h0400, 8'h00);
        do_op(OP_UPD, 16'h0200, 8'h00);
        check("R11 no ovf yet", {31'd0, trig_ovf}, 0);
        do_op(OP_UPD, 16'h0300, 8'h00);
        check("R11 ovf pulse", {31'd0, trig_ovf}, 1);
        @(negedge clk); #1;
        check("R11 ovf one cycle", {31'd0, trig_ovf}, 0);
        begin
            logic [15:0] order [4] = '{16'h0200, 16'h0300, 16'h0400, 16'h0200};
            for (int k = 0; k < 4; k++) begin
                check("R10 order valid", {31'd0, trig_valid}, 1);
                check("R10 order addr", {16'd0, trig_addr}, {16'd0, order[k]});
                do_op(OP_POP, 16'h0200, 0);
            end
        end
        check("R10 drained", {31'd0, trig_valid}, 0);

        // R5: non-zero result pushes nothing
        do_op(OP_UPD, 16'h0400, 8'h05);
        check("R5 nonzero no push", {31'd0, trig_valid}, 0);
        check("R3 count", {24'd0, lkp_count}, 32'hFB);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule